// File: doc/BRIEF.md
# NaN Classifier and Quieter

This combinational unit looks at one binary floating-point operand and reports whether it is an ordinary value, a quiet NaN or a signaling NaN. It handles four storage formats: half precision, bfloat16, single precision and double precision. A format select picks which one applies. The operand is right-aligned in a 64-bit word.

Two run-time controls change how NaNs are read. The first is a polarity bit. It says whether a set top fraction bit marks a quiet NaN (polarity 0) or a signaling NaN (polarity 1). The second is a disable bit. When it is set, signaling NaNs do not exist and every NaN counts as quiet.

The unit also returns two words. One is the operand with any signaling NaN made quiet. The other is the canonical default NaN for the selected format and polarity. A floating-point pipeline uses these at its operand stage. There it detects invalid-operation cases, propagates a quieted input NaN, or substitutes the generated NaN.

Top module: `nan_quieter`

## Requirements
- R1: With polarity 0 and half format (fmt=0), the operand is a quiet NaN exactly when bits [14:9] are all ones. It is a signaling NaN exactly when bits [14:9] equal 6'b111110 and bits [8:0] are nonzero. The two flags are never set together.
- R2: With polarity 1, the roles swap. A field of all ones (exponent plus fraction MSB) means signaling. The exponent of all ones with fraction MSB clear and a nonzero lower fraction means quiet.
- R3: For bfloat16 (fmt=1), the test field is bits [14:6], compared against 9'h1FF and 9'h1FE. The lower fraction is bits [5:0].
- R4: For single precision (fmt=2), the test field is bits [30:22], compared against 9'h1FF and 9'h1FE. The lower fraction is bits [21:0].
- R5: For double precision (fmt=3), the test field is bits [62:51], compared against 12'hFFF and 12'hFFE. The lower fraction is bits [50:0]. Bits of the word above the selected format never affect the flags.
- R6: Zeros, subnormals, normals and infinities report is_qnan=0 and is_snan=0.
- R7: With the disable input high, every NaN reports is_qnan=1 and is_snan=0, under either polarity.
- R8: For a signaling NaN under polarity 0, the quieted word is the operand with the fraction MSB set.
- R9: For a signaling NaN under polarity 1, the quieted word is the operand with the fraction MSB cleared and the bit just below it set.
- R10: When the operand is not a signaling NaN, the quieted word equals the full 64-bit input unchanged.
- R11: With polarity 0, the default NaN has sign 0, all exponent bits set and only the fraction MSB set. All word bits above the format are 0.
- R12: With polarity 1, the default NaN has sign 0, all exponent bits set and every fraction bit set except the MSB. All word bits above the format are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fmt_i | input | 2 | Format: 0 half, 1 bfloat16, 2 single, 3 double |
| operand_i | input | 64 | Operand, right-aligned |
| msb_signals_i | input | 1 | Polarity: 1 when a set fraction MSB marks a signaling NaN |
| snan_off_i | input | 1 | Treat every NaN as quiet |
| is_qnan_o | output | 1 | Operand is a quiet NaN |
| is_snan_o | output | 1 | Operand is a signaling NaN |
| quiet_word_o | output | 64 | Operand with a signaling NaN made quiet |
| dflt_nan_o | output | 64 | Default NaN for the format and polarity |

## Verification
The assertions check properties that hold for every input, whenever the inputs change:
- the two flags are never set together;
- no flag is set when the exponent is not all ones;
- the disable input suppresses the signaling flag;
- a non-signaling operand passes through the quieting path unchanged;
- the quieted word carries the right bit pattern for the current polarity;
- the default NaN has sign 0 and a saturated exponent.

Only the bench's scenarios can show the rest:
- that the field boundaries are right for each format;
- that the polarity swap assigns quiet and signaling the right way round;
- that garbage above the format width is ignored;
- that the default fraction pattern is exact.

The bench covers these with directed corner operands and random, NaN-biased operands for all four formats.

// File: rtl/nanq_pkg.sv
package nanq_pkg;

    localparam int NANQ_WORD_W  = 64;
    localparam int NANQ_NUM_FMT = 4;
    localparam int NANQ_SEL_W   = $clog2(NANQ_NUM_FMT);

    typedef enum logic [NANQ_SEL_W-1:0] {
        FMT_HALF   = 2'd0,
        FMT_BF16   = 2'd1,
        FMT_SINGLE = 2'd2,
        FMT_DOUBLE = 2'd3
    } nanq_fmt_e;

    typedef struct packed {
        logic                   qnan;
        logic                   snan;
        logic [NANQ_WORD_W-1:0] quiet;
        logic [NANQ_WORD_W-1:0] dflt;
    } nanq_res_t;

    function automatic int nanq_exp_bits(input int idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            2:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int nanq_frac_bits(input int idx);
        case (idx)
            0:       return 10;
            1:       return 7;
            2:       return 23;
            default: return 52;
        endcase
    endfunction

endpackage

// File: rtl/nanq_classify.sv
module nanq_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              msb_signals_i,
    input  logic              snan_off_i,
    output logic              qnan_o,
    output logic              snan_o
);
    localparam int LOW_W = FRAC_W - 1;

    logic exp_sat;
    logic top_bit;
    logic low_nz;
    logic any_nan;
    logic top_class;   // NaN with fraction MSB set
    logic low_class;   // NaN with fraction MSB clear

    always_comb begin
        exp_sat   = &exp_i;
        top_bit   = frac_i[FRAC_W-1];
        low_nz    = |frac_i[LOW_W-1:0];
        any_nan   = exp_sat && (top_bit || low_nz);
        top_class = exp_sat && top_bit;
        low_class = exp_sat && !top_bit && low_nz;
        if (snan_off_i) begin
            qnan_o = any_nan;
            snan_o = 1'b0;
        end else if (msb_signals_i) begin
            qnan_o = low_class;
            snan_o = top_class;
        end else begin
            qnan_o = top_class;
            snan_o = low_class;
        end
    end

    always_comb begin
        if (!(&exp_i)) begin
            p_non_nan_r6: assert (!qnan_o && !snan_o)
                else $error("non-NaN operand flagged");
        end
    end

endmodule

// File: rtl/nanq_slice.sv
module nanq_slice
    import nanq_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [NANQ_WORD_W-1:0] word_i,
    input  logic                   msb_signals_i,
    input  logic                   snan_off_i,
    output nanq_res_t              res_o
);
    localparam int MSB_POS  = FRAC_W - 1;
    localparam int EXP_LSB  = FRAC_W;
    localparam int SIGN_POS = EXP_W + FRAC_W;

    logic q_flag;
    logic s_flag;

    nanq_classify #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_cls (
        .exp_i         (word_i[EXP_LSB +: EXP_W]),
        .frac_i        (word_i[FRAC_W-1:0]),
        .msb_signals_i (msb_signals_i),
        .snan_off_i    (snan_off_i),
        .qnan_o        (q_flag),
        .snan_o        (s_flag)
    );

    always_comb begin
        res_o.qnan  = q_flag;
        res_o.snan  = s_flag;
        res_o.quiet = word_i;
        if (s_flag) begin
            if (msb_signals_i) begin
                res_o.quiet[MSB_POS]   = 1'b0;
                res_o.quiet[MSB_POS-1] = 1'b1;
            end else begin
                res_o.quiet[MSB_POS]   = 1'b1;
            end
        end
        res_o.dflt = '0;
        res_o.dflt[EXP_LSB +: EXP_W] = '1;
        if (msb_signals_i) begin
            res_o.dflt[MSB_POS-1:0] = '1;
        end else begin
            res_o.dflt[MSB_POS] = 1'b1;
        end
    end

    always_comb begin
        p_excl_r1: assert (!(q_flag && s_flag))
            else $error("both NaN flags set");
        if (snan_off_i) begin
            p_off_r7: assert (!s_flag)
                else $error("signaling flag while disabled");
        end
        if (!s_flag) begin
            p_pass_r10: assert (res_o.quiet == word_i)
                else $error("quiet word altered");
        end
        if (s_flag && !msb_signals_i) begin
            p_quiet_r8: assert (res_o.quiet[MSB_POS] && (&res_o.quiet[EXP_LSB +: EXP_W]))
                else $error("polarity-0 quieting wrong");
        end
        if (s_flag && msb_signals_i) begin
            p_quiet_r9: assert (!res_o.quiet[MSB_POS] && res_o.quiet[MSB_POS-1])
                else $error("polarity-1 quieting wrong");
        end
        p_dflt_r11: assert ((&res_o.dflt[EXP_LSB +: EXP_W]) && !res_o.dflt[SIGN_POS])
            else $error("default NaN exponent or sign wrong");
    end

endmodule

// File: rtl/nan_quieter.sv
module nan_quieter
    import nanq_pkg::*;
(
    input  logic [NANQ_SEL_W-1:0]  fmt_i,
    input  logic [NANQ_WORD_W-1:0] operand_i,
    input  logic                   msb_signals_i,
    input  logic                   snan_off_i,
    output logic                   is_qnan_o,
    output logic                   is_snan_o,
    output logic [NANQ_WORD_W-1:0] quiet_word_o,
    output logic [NANQ_WORD_W-1:0] dflt_nan_o
);
    nanq_res_t lane_res [NANQ_NUM_FMT];
    nanq_res_t pick;

    for (genvar g = 0; g < NANQ_NUM_FMT; g++) begin : g_fmt
        nanq_slice #(
            .EXP_W  (nanq_exp_bits(g)),
            .FRAC_W (nanq_frac_bits(g))
        ) u_slice (
            .word_i        (operand_i),
            .msb_signals_i (msb_signals_i),
            .snan_off_i    (snan_off_i),
            .res_o         (lane_res[g])
        );
    end

    always_comb begin
        pick         = lane_res[fmt_i];
        is_qnan_o    = pick.qnan;
        is_snan_o    = pick.snan;
        quiet_word_o = pick.quiet;
        dflt_nan_o   = pick.dflt;
    end

endmodule

// File: tb/nan_quieter_tb.sv
module nan_quieter_tb;
    logic        clk = 1'b0;
    logic [1:0]  fmt;
    logic [63:0] opnd;
    logic        pol;
    logic        off;
    logic        q_o;
    logic        s_o;
    logic [63:0] qw_o;
    logic [63:0] dn_o;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    nan_quieter u_dut (
        .fmt_i         (fmt),
        .operand_i     (opnd),
        .msb_signals_i (pol),
        .snan_off_i    (off),
        .is_qnan_o     (q_o),
        .is_snan_o     (s_o),
        .quiet_word_o  (qw_o),
        .dflt_nan_o    (dn_o)
    );

    function automatic int ew(input logic [1:0] f);
        return (f == 2'd0) ? 5 : (f == 2'd3) ? 11 : 8;
    endfunction

    function automatic int fw(input logic [1:0] f);
        return (f == 2'd0) ? 10 : (f == 2'd1) ? 7 : (f == 2'd2) ? 23 : 52;
    endfunction

    task automatic ref_model(input logic [1:0] f, input logic [63:0] x,
                             input logic p, input logic d,
                             output logic eq, output logic es,
                             output logic [63:0] eqw, output logic [63:0] edn);
        int e;
        int fr;
        logic sat;
        logic low;
        logic top;
        e = ew(f);
        fr = fw(f);
        sat = 1'b1;
        for (int i = fr; i < fr + e; i++) if (!x[i]) sat = 1'b0;
        low = 1'b0;
        for (int i = 0; i < fr - 1; i++) low = low | x[i];
        top = x[fr-1];
        eq = 1'b0;
        es = 1'b0;
        if (sat && (top || low)) begin
            if (d) eq = 1'b1;
            else if (top != p) eq = 1'b1;
            else es = 1'b1;
        end
        eqw = x;
        if (es) begin
            if (p) begin
                eqw[fr-1] = 1'b0;
                eqw[fr-2] = 1'b1;
            end else begin
                eqw[fr-1] = 1'b1;
            end
        end
        edn = 64'd0;
        for (int i = fr; i < fr + e; i++) edn[i] = 1'b1;
        if (p) begin
            for (int i = 0; i < fr - 1; i++) edn[i] = 1'b1;
        end else begin
            edn[fr-1] = 1'b1;
        end
    endtask

    task automatic run(input string tag, input logic [1:0] f, input logic [63:0] x,
                       input logic p, input logic d);
        logic eq;
        logic es;
        logic [63:0] eqw;
        logic [63:0] edn;
        @(negedge clk);
        fmt = f;
        opnd = x;
        pol = p;
        off = d;
        #1;
        ref_model(f, x, p, d, eq, es, eqw, edn);
        total++;
        if (q_o !== eq || s_o !== es) begin
            bad++;
            $display("FAIL %s flags fmt=%0d x=%h: got q=%b s=%b exp q=%b s=%b",
                     tag, f, x, q_o, s_o, eq, es);
        end
        total++;
        if (qw_o !== eqw) begin
            bad++;
            $display("FAIL %s quiet fmt=%0d x=%h: got %h exp %h", tag, f, x, qw_o, eqw);
        end
        total++;
        if (dn_o !== edn) begin
            bad++;
            $display("FAIL %s default fmt=%0d p=%b: got %h exp %h", tag, f, p, dn_o, edn);
        end
    endtask

    initial begin
        fork
            begin
                #700000;
                if (!done) begin
                    bad++;
                    total++;
                    $display("FAIL watchdog expired");
                    $display("test done: total=%0d bad=%0d", total, bad);
                    $finish;
                end
            end
        join_none
        fmt = 2'd0;
        opnd = '0;
        pol = 1'b0;
        off = 1'b0;
        // reset-like idle state: zero operand
        run("R6", 2'd0, 64'h0, 1'b0, 1'b0);
        // half, polarity 0
        run("R1", 2'd0, 64'h7E00, 1'b0, 1'b0);
        run("R1", 2'd0, 64'h7C01, 1'b0, 1'b0);
        run("R6", 2'd0, 64'h7C00, 1'b0, 1'b0);
        run("R8", 2'd0, 64'hFD00, 1'b0, 1'b0);
        // polarity swap
        run("R2", 2'd0, 64'h7E00, 1'b1, 1'b0);
        run("R9", 2'd0, 64'h7F55, 1'b1, 1'b0);
        run("R2", 2'd0, 64'h7C01, 1'b1, 1'b0);
        // bfloat16, single, double, with high garbage
        run("R3", 2'd1, 64'hABCD_0000_0000_7FC0, 1'b0, 1'b0);
        run("R3", 2'd1, 64'h0000_0000_0000_7F81, 1'b0, 1'b0);
        run("R4", 2'd2, 64'h1234_5678_7FC0_0000, 1'b0, 1'b0);
        run("R4", 2'd2, 64'h0000_0000_FF80_0001, 1'b0, 1'b0);
        run("R4", 2'd2, 64'h0000_0000_7F80_0000, 1'b1, 1'b0);
        run("R5", 2'd3, 64'h7FF8_0000_0000_0000, 1'b0, 1'b0);
        run("R5", 2'd3, 64'hFFF0_0000_0000_0001, 1'b0, 1'b0);
        run("R5", 2'd3, 64'h7FF0_0000_0000_0000, 1'b0, 1'b0);
        run("R9", 2'd3, 64'h7FF8_0000_0000_0000, 1'b1, 1'b0);
        // disable
        run("R7", 2'd2, 64'h7F80_0001, 1'b0, 1'b1);
        run("R7", 2'd3, 64'h7FF8_0000_0000_0000, 1'b1, 1'b1);
        // passthrough and defaults
        run("R10", 2'd2, 64'hDEAD_BEEF_3F80_0000, 1'b0, 1'b0);
        run("R11", 2'd3, 64'h0, 1'b0, 1'b0);
        run("R12", 2'd1, 64'h0, 1'b1, 1'b0);
        run("R12", 2'd0, 64'h0, 1'b1, 1'b0);
        // random, NaN biased
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            logic [1:0]  f;
            logic [63:0] x;
            int fr;
            int e;
            f = 2'($urandom);
            x = {$urandom, $urandom};
            fr = fw(f);
            e = ew(f);
            if ($urandom % 4 != 0) begin
                for (int i = fr; i < fr + e; i++) x[i] = 1'b1;
            end
            if ($urandom % 4 == 0) begin
                for (int i = 0; i < fr - 1; i++) x[i] = 1'b0;
            end
            run("R13rand", f, x, 1'($urandom), ($urandom % 5) == 0);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule